// File: doc/BRIEF.md
# Register Rename Unit with Free-Tag Pool

This block sits in the rename stage of an out-of-order core. It translates the small set of architectural register numbers into tags of a larger physical register file. For each instruction presented, it looks up the current physical tags of both source operands. When the instruction writes a destination, the block hands out a fresh physical tag from a pool of unused tags. It also returns the tag that the destination held before, so that the commit stage can free that tag later.

Alongside the speculative map, the block keeps a second map that tracks only committed state. Commit drives a release port carrying the committing instruction's destination, its new tag and the tag it displaced. The displaced tag goes back to the pool, and the committed map learns the new binding. On a misprediction or exception, a single recovery pulse copies the committed map over the speculative one. The same pulse rebuilds the pool as every tag that the committed map does not hold, which undoes every mapping made after the last commit.

The default size is 32 architectural and 64 physical registers. Architectural register 0 is hard-wired to physical tag 0 and never takes a tag from the pool.

Top module: `reg_rename`

## Requirements
- R1: After reset, architectural register i maps to physical tag i for every i, and only tags 32 to 63 are in the pool.
- R2: The source tags are read combinationally from the speculative map. If a source of an instruction names that instruction's own destination, it returns the mapping from before the instruction.
- R3: A granted rename whose write flag is 1 and whose destination is not 0 takes the lowest-numbered free tag as its new tag. It returns the destination's previous tag as the old tag. From the next cycle on, the destination maps to the new tag, and the new tag has left the pool.
- R4: A source naming architectural register 0 always returns tag 0. A rename whose destination is 0, or whose write flag is 0, takes no tag from the pool. It returns 0 as both new tag and old tag, and it is granted even when the pool is empty.
- R5: When a rename needs a tag and the pool is empty, the grant is 0 and no map or pool state changes.
- R6: A release with a non-zero architectural destination returns its old tag to the pool from the next cycle on. It also records the architectural destination as mapped to the release's new tag in the committed map.
- R7: While recovery is high, the grant is 0. In the next cycle, the speculative map equals the committed map, and the pool holds exactly the tags that the committed map does not hold, which makes 32 free tags.
- R8: A release in the same cycle as recovery is applied to the committed map before the copy, so the restored state includes it.
- R9: A tag released in a given cycle is not available to a rename in that same cycle, but it is available from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| renValid | input | 1 | A rename request is present |
| renWritesDst | input | 1 | The instruction writes a destination register |
| renSrcA | input | 5 | First source architectural register |
| renSrcB | input | 5 | Second source architectural register |
| renDst | input | 5 | Destination architectural register |
| renGrant | output | 1 | The request is accepted this cycle |
| renTagA | output | 6 | Physical tag of the first source |
| renTagB | output | 6 | Physical tag of the second source |
| renNewTag | output | 6 | Newly allocated destination tag, 0 when none is allocated |
| renOldTag | output | 6 | Previous destination tag, 0 when none is allocated |
| relValid | input | 1 | Commit releases an instruction |
| relArchDst | input | 5 | Architectural destination of the committing instruction |
| relNewTag | input | 6 | Tag that the committing instruction allocated |
| relOldTag | input | 6 | Tag that the committing instruction displaced |
| recover | input | 1 | Restore the committed state |

## Verification
The bench renames an instruction whose source is its own destination, and checks that the source sees the old binding. A design that updated the map first would hand the instruction its own result tag. It drains the pool completely, then checks that a needy rename is refused while a rename of register 0 still passes. A leak on the stalled request would appear as a changed source mapping afterwards. It also releases a tag in the same cycle as a rename and checks that the tag is reused only a cycle later. Finally, it fires a recovery in the same cycle as a release: a design that ignored the release would restore a stale binding, and one that rebuilt the pool wrongly would hand out the wrong lowest free tag.

// File: rtl/rr_pkg.sv
package rr_pkg;

  // Strobes from the control to the state-holding parts
  typedef struct packed {
    logic doAlloc;
    logic doRelease;
    logic doRecover;
  } rrStrobe_t;

endpackage

// File: rtl/rr_ctrl.sv
module rr_ctrl
  import rr_pkg::*;
#(
  parameter int ARCH_REGS = 32,
  localparam int ARCH_W = $clog2(ARCH_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              renValid,
  input  logic              renWritesDst,
  input  logic [ARCH_W-1:0] renDst,
  input  logic              relValid,
  input  logic [ARCH_W-1:0] relArchDst,
  input  logic              recover,
  input  logic              anyFree,
  output logic              needAlloc,
  output logic              renGrant,
  output rrStrobe_t         strobe
);

  always_comb begin
    needAlloc        = renWritesDst && (renDst != '0);
    renGrant         = renValid && !recover && (!needAlloc || anyFree);
    strobe.doAlloc   = renGrant && needAlloc;
    strobe.doRelease = relValid && (relArchDst != '0);
    strobe.doRecover = recover;
  end

  AST_STALL_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (renValid && needAlloc && !anyFree) |-> !strobe.doAlloc) else $error("stall"); // R5

  AST_NO_GRANT_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
    recover |-> !strobe.doAlloc) else $error("recover grant"); // R7

endmodule

// File: rtl/rr_maptable.sv
module rr_maptable
  import rr_pkg::*;
#(
  parameter int ARCH_REGS = 32,
  parameter int PHYS_REGS = 64,
  localparam int ARCH_W = $clog2(ARCH_REGS),
  localparam int TAG_W  = $clog2(PHYS_REGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  rrStrobe_t            strobe,
  input  logic [ARCH_W-1:0]    srcA,
  input  logic [ARCH_W-1:0]    srcB,
  input  logic [ARCH_W-1:0]    dst,
  input  logic [TAG_W-1:0]     allocTag,
  input  logic [ARCH_W-1:0]    relArchDst,
  input  logic [TAG_W-1:0]     relNewTag,
  output logic [TAG_W-1:0]     tagA,
  output logic [TAG_W-1:0]     tagB,
  output logic [TAG_W-1:0]     oldTag,
  output logic [PHYS_REGS-1:0] commitMask
);

  logic [TAG_W-1:0] specTab   [ARCH_REGS];
  logic [TAG_W-1:0] commitTab [ARCH_REGS];
  logic [TAG_W-1:0] commitNext[ARCH_REGS];

  // Lookups see the map as it stood before this cycle's update
  always_comb begin
    tagA   = specTab[srcA];
    tagB   = specTab[srcB];
    oldTag = specTab[dst];
  end

  // Committed map including a release arriving this cycle
  always_comb begin
    for (int i = 0; i < ARCH_REGS; i++) begin
      commitNext[i] = commitTab[i];
    end
    if (strobe.doRelease) begin
      commitNext[relArchDst] = relNewTag;
    end
  end

  // Tags held by the committed map, used to rebuild the pool
  always_comb begin
    commitMask    = '0;
    commitMask[0] = 1'b1;
    for (int i = 1; i < ARCH_REGS; i++) begin
      commitMask[commitNext[i]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ARCH_REGS; i++) begin
        specTab[i]   <= TAG_W'(i);
        commitTab[i] <= TAG_W'(i);
      end
    end else begin
      for (int i = 0; i < ARCH_REGS; i++) begin
        commitTab[i] <= commitNext[i];
      end
      if (strobe.doRecover) begin
        for (int i = 0; i < ARCH_REGS; i++) begin
          specTab[i] <= commitNext[i];
        end
      end else if (strobe.doAlloc) begin
        specTab[dst] <= allocTag;
      end
    end
  end

  AST_ZERO_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (srcA == '0) |-> (tagA == '0)) else $error("zero source"); // R4

endmodule

// File: rtl/rr_freelist.sv
module rr_freelist
  import rr_pkg::*;
#(
  parameter int ARCH_REGS = 32,
  parameter int PHYS_REGS = 64,
  localparam int TAG_W = $clog2(PHYS_REGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  rrStrobe_t            strobe,
  input  logic [TAG_W-1:0]     relTag,
  input  logic [PHYS_REGS-1:0] commitMask,
  output logic                 anyFree,
  output logic [TAG_W-1:0]     allocTag
);

  logic [PHYS_REGS-1:0] freeBits;
  logic [PHYS_REGS-1:0] allocOh;
  logic [PHYS_REGS-1:0] relOh;
  logic                 pastValid;

  // Lowest-numbered free tag wins
  always_comb begin
    allocTag = '0;
    for (int i = PHYS_REGS - 1; i >= 0; i--) begin
      if (freeBits[i]) allocTag = TAG_W'(i);
    end
    anyFree = |freeBits;
  end

  always_comb begin
    allocOh = '0;
    relOh   = '0;
    if (strobe.doAlloc)   allocOh[allocTag] = 1'b1;
    if (strobe.doRelease) relOh[relTag]     = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PHYS_REGS; i++) begin
        freeBits[i] <= (i >= ARCH_REGS);
      end
      pastValid <= 1'b0;
    end else begin
      pastValid <= 1'b1;
      if (strobe.doRecover) begin
        freeBits <= ~commitMask;
      end else begin
        freeBits <= (freeBits & ~allocOh) | relOh;
      end
    end
  end

  AST_RELEASE_NOT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.doRelease |-> !freeBits[relTag]) else $error("double free"); // R6

  AST_RECOVER_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (pastValid && $past(strobe.doRecover)) |-> ($countones(freeBits) == PHYS_REGS - ARCH_REGS))
    else $error("recover count"); // R7

  AST_FREE_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n)
    (pastValid && !$past(strobe.doRecover)) |->
      ($countones(freeBits) == $past($countones(freeBits))
        - int'($past(strobe.doAlloc)) + int'($past(strobe.doRelease))))
    else $error("conserve"); // R3

endmodule

// File: rtl/reg_rename.sv
module reg_rename
  import rr_pkg::*;
#(
  parameter int ARCH_REGS = 32,
  parameter int PHYS_REGS = 64,
  localparam int ARCH_W = $clog2(ARCH_REGS),
  localparam int TAG_W  = $clog2(PHYS_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              renValid,
  input  logic              renWritesDst,
  input  logic [ARCH_W-1:0] renSrcA,
  input  logic [ARCH_W-1:0] renSrcB,
  input  logic [ARCH_W-1:0] renDst,
  output logic              renGrant,
  output logic [TAG_W-1:0]  renTagA,
  output logic [TAG_W-1:0]  renTagB,
  output logic [TAG_W-1:0]  renNewTag,
  output logic [TAG_W-1:0]  renOldTag,
  input  logic              relValid,
  input  logic [ARCH_W-1:0] relArchDst,
  input  logic [TAG_W-1:0]  relNewTag,
  input  logic [TAG_W-1:0]  relOldTag,
  input  logic              recover
);

  rrStrobe_t            strobe;
  logic                 needAlloc;
  logic                 anyFree;
  logic [TAG_W-1:0]     allocTag;
  logic [TAG_W-1:0]     mapOld;
  logic [PHYS_REGS-1:0] commitMask;

  rr_ctrl #(.ARCH_REGS(ARCH_REGS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .renValid(renValid), .renWritesDst(renWritesDst),
    .renDst(renDst), .relValid(relValid), .relArchDst(relArchDst),
    .recover(recover), .anyFree(anyFree), .needAlloc(needAlloc),
    .renGrant(renGrant), .strobe(strobe)
  );

  rr_maptable #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_map (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .srcA(renSrcA), .srcB(renSrcB),
    .dst(renDst), .allocTag(allocTag), .relArchDst(relArchDst),
    .relNewTag(relNewTag), .tagA(renTagA), .tagB(renTagB), .oldTag(mapOld),
    .commitMask(commitMask)
  );

  rr_freelist #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_free (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .relTag(relOldTag),
    .commitMask(commitMask), .anyFree(anyFree), .allocTag(allocTag)
  );

  always_comb begin
    renNewTag = needAlloc ? allocTag : '0;
    renOldTag = needAlloc ? mapOld   : '0;
  end

  AST_NEW_DIFFERS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (renGrant && needAlloc) |-> (renNewTag != renOldTag)) else $error("new==old"); // R3

  AST_NEW_NOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (renGrant && needAlloc) |-> (renNewTag != '0)) else $error("alloc zero"); // R4

endmodule

// File: tb/reg_rename_bench.sv
module reg_rename_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       renValid = 1'b0, renWritesDst = 1'b0;
  logic [4:0] renSrcA = '0, renSrcB = '0, renDst = '0;
  logic       renGrant;
  logic [5:0] renTagA, renTagB, renNewTag, renOldTag;
  logic       relValid = 1'b0;
  logic [4:0] relArchDst = '0;
  logic [5:0] relNewTag = '0, relOldTag = '0;
  logic       recover = 1'b0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  reg_rename u_reg_rename (
    .clk(clk), .rst_n(rst_n), .renValid(renValid), .renWritesDst(renWritesDst),
    .renSrcA(renSrcA), .renSrcB(renSrcB), .renDst(renDst), .renGrant(renGrant),
    .renTagA(renTagA), .renTagB(renTagB), .renNewTag(renNewTag),
    .renOldTag(renOldTag), .relValid(relValid), .relArchDst(relArchDst),
    .relNewTag(relNewTag), .relOldTag(relOldTag), .recover(recover)
  );

  typedef struct packed {
    logic       rv;
    logic       wr;
    logic [4:0] sa;
    logic [4:0] sb;
    logic [4:0] dst;
    logic       relV;
    logic [4:0] relA;
    logic [5:0] relN;
    logic [5:0] relO;
    logic       rec;
    logic       eg;
    logic [5:0] ea;
    logic [5:0] eb;
    logic [5:0] en;
    logic [5:0] eo;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VEC [NVEC] = '{
    // R3 first allocation
    '{1'b1,1'b1,5'd1,5'd2,5'd3, 1'b0,5'd0,6'd0,6'd0, 1'b0, 1'b1,6'd1,6'd2,6'd32,6'd3},
    // R2 sources equal own destination
    '{1'b1,1'b1,5'd3,5'd3,5'd3, 1'b0,5'd0,6'd0,6'd0, 1'b0, 1'b1,6'd32,6'd32,6'd33,6'd32},
    // R4 destination zero
    '{1'b1,1'b1,5'd0,5'd3,5'd0, 1'b0,5'd0,6'd0,6'd0, 1'b0, 1'b1,6'd0,6'd33,6'd0,6'd0},
    // R4 no write
    '{1'b1,1'b0,5'd5,5'd3,5'd5, 1'b0,5'd0,6'd0,6'd0, 1'b0, 1'b1,6'd5,6'd33,6'd0,6'd0},
    '{1'b1,1'b1,5'd3,5'd4,5'd4, 1'b0,5'd0,6'd0,6'd0, 1'b0, 1'b1,6'd33,6'd4,6'd34,6'd4},
    // R9 release of tag 3 not visible this cycle
    '{1'b1,1'b1,5'd4,5'd1,5'd1, 1'b1,5'd3,6'd32,6'd3, 1'b0, 1'b1,6'd34,6'd1,6'd35,6'd1},
    // R6 released tag 3 reused
    '{1'b1,1'b1,5'd1,5'd2,5'd2, 1'b0,5'd0,6'd0,6'd0, 1'b0, 1'b1,6'd35,6'd2,6'd3,6'd2},
    '{1'b0,1'b0,5'd0,5'd0,5'd0, 1'b1,5'd3,6'd33,6'd32, 1'b0, 1'b0,6'd0,6'd0,6'd0,6'd0},
    '{1'b1,1'b1,5'd7,5'd7,5'd7, 1'b0,5'd0,6'd0,6'd0, 1'b0, 1'b1,6'd7,6'd7,6'd32,6'd7},
    // R7 recovery cycle refuses rename
    '{1'b1,1'b1,5'd3,5'd1,5'd1, 1'b0,5'd0,6'd0,6'd0, 1'b1, 1'b0,6'd0,6'd0,6'd0,6'd0},
    // R7 restored map and rebuilt pool
    '{1'b1,1'b1,5'd3,5'd1,5'd1, 1'b0,5'd0,6'd0,6'd0, 1'b0, 1'b1,6'd33,6'd1,6'd3,6'd1},
    '{1'b1,1'b1,5'd2,5'd4,5'd6, 1'b0,5'd0,6'd0,6'd0, 1'b0, 1'b1,6'd2,6'd4,6'd32,6'd6}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    renValid = 1'b0; renWritesDst = 1'b0; renSrcA = '0; renSrcB = '0; renDst = '0;
    relValid = 1'b0; relArchDst = '0; relNewTag = '0; relOldTag = '0; recover = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    idle();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic rename(input logic wr, input logic [4:0] sa, input logic [4:0] sb,
                        input logic [4:0] d);
    @(negedge clk);
    idle();
    renValid = 1'b1; renWritesDst = wr; renSrcA = sa; renSrcB = sb; renDst = d;
    #1;
  endtask

  initial begin
    fork
      begin
        doReset();
        // R1 identity map after reset, checked without renaming
        for (int i = 0; i < 32; i++) begin
          @(negedge clk);
          idle();
          renSrcA = 5'(i); renSrcB = 5'(31 - i);
          #1;
          check("R1", "tagA", int'(renTagA), i);
          check("R1", "tagB", int'(renTagB), 31 - i);
        end

        for (int v = 0; v < NVEC; v++) begin
          @(negedge clk);
          renValid = VEC[v].rv; renWritesDst = VEC[v].wr;
          renSrcA = VEC[v].sa; renSrcB = VEC[v].sb; renDst = VEC[v].dst;
          relValid = VEC[v].relV; relArchDst = VEC[v].relA;
          relNewTag = VEC[v].relN; relOldTag = VEC[v].relO; recover = VEC[v].rec;
          #1;
          check("R3", $sformatf("vec%0d grant", v), int'(renGrant), int'(VEC[v].eg));
          if (VEC[v].eg) begin
            check("R2", $sformatf("vec%0d tagA", v), int'(renTagA), int'(VEC[v].ea));
            check("R2", $sformatf("vec%0d tagB", v), int'(renTagB), int'(VEC[v].eb));
            check("R3", $sformatf("vec%0d new", v), int'(renNewTag), int'(VEC[v].en));
            check("R3", $sformatf("vec%0d old", v), int'(renOldTag), int'(VEC[v].eo));
          end
        end

        // Drain the pool: R1 pool holds 32..63, handed out lowest first
        doReset();
        for (int k = 0; k < 32; k++) begin
          rename(1'b1, 5'd1, 5'd0, 5'd1);
          check("R1", "drain grant", int'(renGrant), 1);
          check("R1", "drain new", int'(renNewTag), 32 + k);
          check("R3", "drain old", int'(renOldTag), (k == 0) ? 1 : 31 + k);
        end
        // R5 empty pool refuses
        rename(1'b1, 5'd1, 5'd2, 5'd1);
        check("R5", "empty grant", int'(renGrant), 0);
        // R4 zero destination still granted
        rename(1'b1, 5'd0, 5'd0, 5'd0);
        check("R4", "zero dst grant", int'(renGrant), 1);
        check("R4", "zero dst new", int'(renNewTag), 0);
        check("R4", "zero src", int'(renTagA), 0);
        // R5 refused request left the map unchanged
        @(negedge clk);
        idle();
        renSrcA = 5'd1;
        #1;
        check("R5", "map after stall", int'(renTagA), 63);
        // R6 release frees tag 1
        @(negedge clk);
        idle();
        relValid = 1'b1; relArchDst = 5'd1; relNewTag = 6'd32; relOldTag = 6'd1;
        rename(1'b1, 5'd1, 5'd0, 5'd1);
        check("R6", "reuse grant", int'(renGrant), 1);
        check("R6", "reuse new", int'(renNewTag), 1);
        check("R6", "reuse old", int'(renOldTag), 63);
        // R8 recovery with a same-cycle release
        @(negedge clk);
        idle();
        recover = 1'b1;
        relValid = 1'b1; relArchDst = 5'd1; relNewTag = 6'd33; relOldTag = 6'd32;
        #1;
        check("R7", "recover grant", int'(renGrant), 0);
        rename(1'b1, 5'd1, 5'd2, 5'd2);
        check("R8", "restored src", int'(renTagA), 33);
        check("R7", "rebuilt pool new", int'(renNewTag), 1);
        check("R7", "restored old", int'(renOldTag), 2);
        @(negedge clk);
        idle();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule